// File: doc/BRIEF.md
# Frame Transmit Retry Controller

This block is the transmit half of a packet MAC. A host fills a byte-wide frame buffer and then controls the block through three small registers. The first buffer byte holds a length L. Bytes 1 to 4 hold the destination address, byte 5 holds the frame control field, and the payload follows, so L counts every byte after the length byte. A write that sets the send bit starts an operation. The block emits a preamble and a start delimiter, then buffer bytes 0 to L, then a 16-bit check sequence. All of this goes out on a byte stream with a valid/ready handshake.

When the host asks for acknowledgement, the block opens a fixed wait window after the last byte of each attempt. A pulse on `ack_in` inside that window ends the operation with success. If the window closes with no ack, the block sends the whole frame again, until the programmed retry limit is used up. At the end the block records the number of retransmissions and a fail flag, sets a completion interrupt and clears the send bit on its own.

Top module: `frame_tx_retry`

## Requirements
- R1: After reset, the control register (address 0) reads 0x30, the status register (address 1) reads 0x00, the interrupt register (address 2) reads 0x00, and `tx_valid` is low.
- R2: Each attempt presents the same bytes on the stream, in this order: PRE_LEN bytes of 0x55, one byte 0xA7, buffer bytes 0 through L, the check sequence low byte, then the check sequence high byte. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value.
- R3: The check sequence is a CRC-16 with polynomial 0x1021 and initial value 0. It is processed most significant bit first, with no reflection and no final inversion, over buffer bytes 0 through L.
- R4: A control write with bit 0 set, made while idle, starts an operation. Control bit 0 reads 1 while the operation runs and returns to 0 once it completes.
- R5: When control bit 2 (ack request) is 0, the frame is sent exactly once. The status register then reads 0x00 and interrupt bit 0 is set.
- R6: When ack request is set, an `ack_in` pulse within ACK_WAIT cycles after an attempt's last byte ends the operation with success. Status then reads {retransmissions[7:4], 000, 0}.
- R7: When ack request is set and no ack arrives, the frame is resent until the retransmission count equals control bits 7:4, giving limit+1 attempts. Status then reads {limit, 000, 1}.
- R8: An `ack_in` pulse while a frame is still being sent is ignored.
- R9: A read of the interrupt register clears interrupt bit 0.
- R10: While an operation runs, writes to the control register and to the frame buffer have no effect.
- R11: With ack request set and a retry limit of 0, an attempt with no ack ends the operation after one attempt, and status reads 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 clears the interrupt) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 interrupt |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| buf_we | input | 1 | Frame buffer write enable |
| buf_addr | input | BUF_AW (6) | Frame buffer byte address |
| buf_wdata | input | 8 | Frame buffer write data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| ack_in | input | 1 | Single-cycle acknowledgement pulse |

## Verification
The main function is tried in four ways: with no ack request, with an ack on the first attempt, with an ack on a later attempt, and with no ack at all. These separate a success that comes with zero retransmissions, a success that comes after some, and a failure at the limit. An ack placed during the preamble tells apart a design that honours the wait window from one that takes the ack at any time. Random frame lengths, random payloads and a randomly stalling sink check that the delimiter, the byte order and the CRC stay correct under backpressure. A write made while an operation runs, followed by a second transmission, shows whether that write reached the registers or the buffer.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

    localparam int RETRY_W = 4;

    localparam logic [7:0]  PREAMBLE_BYTE = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hA7;
    localparam logic [7:0]  CTRL_RESET    = 8'h30;
    localparam logic [15:0] CRC_POLY      = 16'h1021;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_IRQ  = 2'd2;

    typedef enum logic [2:0] {
        SER_IDLE, SER_PRE, SER_SFD, SER_BODY, SER_FCS_LO, SER_FCS_HI
    } ser_state_t;

    typedef enum logic [1:0] {
        ATT_IDLE, ATT_SEND, ATT_WAIT
    } att_state_t;

    typedef struct packed {
        logic               ack_req;
        logic [RETRY_W-1:0] limit;
    } tx_cfg_t;

    typedef struct packed {
        logic [RETRY_W-1:0] retries;
        logic               fail;
    } tx_result_t;

    // Bit-serial CRC-16 update, MSB of the byte first.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                               input logic [7:0]  data);
        logic [15:0] c;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            if (c[15] ^ data[i]) c = (c << 1) ^ CRC_POLY;
            else                 c = c << 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/tx_host_regs.sv
module tx_host_regs
    import frame_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       busy,
    input  logic       done,
    input  tx_result_t result,
    output logic       start,
    output tx_cfg_t    start_cfg
);

    logic               send_q;
    logic               ackreq_q;
    logic [RETRY_W-1:0] lim_q;
    tx_result_t         stat_q;
    logic               irq_q;
    logic               wr_ctrl;
    logic               unused_wbits;

    assign wr_ctrl      = reg_wr && (reg_addr == ADDR_CTRL);
    assign start        = wr_ctrl && !busy && reg_wdata[0];
    assign start_cfg    = '{ack_req: reg_wdata[2], limit: reg_wdata[7:4]};
    assign unused_wbits = reg_wdata[3] ^ reg_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            send_q   <= 1'b0;
            ackreq_q <= CTRL_RESET[2];
            lim_q    <= CTRL_RESET[7:4];
            stat_q   <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (done) send_q <= 1'b0;
            if (wr_ctrl && !busy) begin
                send_q   <= reg_wdata[0];
                ackreq_q <= reg_wdata[2];
                lim_q    <= reg_wdata[7:4];
            end
            if (done) begin
                stat_q <= result;
                irq_q  <= 1'b1;
            end else if (reg_rd && reg_addr == ADDR_IRQ) begin
                irq_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {lim_q, 1'b0, ackreq_q, 1'b0, send_q};
            ADDR_STAT: reg_rdata = {stat_q.retries, 3'b000, stat_q.fail};
            ADDR_IRQ:  reg_rdata = {7'd0, irq_q};
            default:   reg_rdata = 8'h00;
        endcase
    end

    p_irq_set_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> irq_q);

    p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADDR_IRQ && !done) |=> !irq_q);

    p_ctrl_locked_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && busy) |=> ($stable(lim_q) && $stable(ackreq_q)));

endmodule

// File: rtl/tx_byte_serializer.sv
module tx_byte_serializer
    import frame_tx_pkg::*;
#(
    parameter int BUF_AW  = 6,
    parameter int PRE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    output logic [BUF_AW-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              frame_done
);

    localparam int PW = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;

    ser_state_t  st;
    logic [7:0]  idx;
    logic [7:0]  len_q;
    logic [PW-1:0] pcnt;
    logic [15:0] crc;

    assign rd_addr  = idx[BUF_AW-1:0];
    assign tx_valid = (st != SER_IDLE);

    always_comb begin
        case (st)
            SER_PRE:    tx_data = PREAMBLE_BYTE;
            SER_SFD:    tx_data = SFD_BYTE;
            SER_BODY:   tx_data = rd_data;
            SER_FCS_LO: tx_data = crc[7:0];
            SER_FCS_HI: tx_data = crc[15:8];
            default:    tx_data = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SER_IDLE;
            idx        <= '0;
            len_q      <= '0;
            pcnt       <= '0;
            crc        <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (st)
                SER_IDLE: if (go) begin
                    st    <= SER_PRE;
                    pcnt  <= '0;
                    crc   <= '0;
                    idx   <= '0;
                    len_q <= rd_data;
                end
                SER_PRE: if (tx_ready) begin
                    if (pcnt == PW'(PRE_LEN - 1)) st <= SER_SFD;
                    else pcnt <= pcnt + 1'b1;
                end
                SER_SFD: if (tx_ready) st <= SER_BODY;
                SER_BODY: if (tx_ready) begin
                    crc <= crc16_step(crc, rd_data);
                    if (idx == len_q) st <= SER_FCS_LO;
                    else idx <= idx + 8'd1;
                end
                SER_FCS_LO: if (tx_ready) st <= SER_FCS_HI;
                SER_FCS_HI: if (tx_ready) begin
                    st         <= SER_IDLE;
                    idx        <= '0;
                    frame_done <= 1'b1;
                end
                default: st <= SER_IDLE;
            endcase
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_go_idle_r4: assert property (@(posedge clk) disable iff (rst)
        go |-> (st == SER_IDLE));

endmodule

// File: rtl/tx_attempt_ctrl.sv
module tx_attempt_ctrl
    import frame_tx_pkg::*;
#(
    parameter int ACK_WAIT = 48
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  tx_cfg_t    cfg,
    input  logic       frame_done,
    input  logic       ack_in,
    output logic       frame_go,
    output logic       busy,
    output logic       done,
    output tx_result_t result
);

    localparam int WW = $clog2(ACK_WAIT + 1);

    att_state_t         st;
    tx_cfg_t            cfg_q;
    logic [RETRY_W-1:0] tries;
    logic [WW-1:0]      wcnt;

    assign busy = (st != ATT_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ATT_IDLE;
            cfg_q    <= '0;
            tries    <= '0;
            wcnt     <= '0;
            frame_go <= 1'b0;
            done     <= 1'b0;
            result   <= '0;
        end else begin
            frame_go <= 1'b0;
            done     <= 1'b0;
            case (st)
                ATT_IDLE: if (start) begin
                    cfg_q    <= cfg;
                    tries    <= '0;
                    frame_go <= 1'b1;
                    st       <= ATT_SEND;
                end
                ATT_SEND: if (frame_done) begin
                    if (cfg_q.ack_req) begin
                        st   <= ATT_WAIT;
                        wcnt <= '0;
                    end else begin
                        st     <= ATT_IDLE;
                        done   <= 1'b1;
                        result <= '{retries: tries, fail: 1'b0};
                    end
                end
                ATT_WAIT: begin
                    if (ack_in) begin
                        st     <= ATT_IDLE;
                        done   <= 1'b1;
                        result <= '{retries: tries, fail: 1'b0};
                    end else if (wcnt == WW'(ACK_WAIT - 1)) begin
                        if (tries == cfg_q.limit) begin
                            st     <= ATT_IDLE;
                            done   <= 1'b1;
                            result <= '{retries: tries, fail: 1'b1};
                        end else begin
                            tries    <= tries + 1'b1;
                            frame_go <= 1'b1;
                            st       <= ATT_SEND;
                        end
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: st <= ATT_IDLE;
            endcase
        end
    end

    p_retry_bound_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tries <= cfg_q.limit));

    p_fail_at_limit_r7: assert property (@(posedge clk) disable iff (rst)
        (done && result.fail) |-> (result.retries == cfg_q.limit));

    p_early_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ATT_SEND && cfg_q.ack_req && ack_in && !frame_done) |=> !done);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/frame_tx_retry.sv
module frame_tx_retry
    import frame_tx_pkg::*;
#(
    parameter int  BUF_DEPTH = 64,
    parameter int  PRE_LEN   = 4,
    parameter int  ACK_WAIT  = 48,
    localparam int BUF_AW    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              buf_we,
    input  logic [BUF_AW-1:0] buf_addr,
    input  logic [7:0]        buf_wdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    input  logic              ack_in
);

    logic [7:0]        frame_mem [BUF_DEPTH];
    logic [BUF_AW-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              start, busy, done, frame_go, frame_done;
    tx_cfg_t           start_cfg;
    tx_result_t        result;

    always_ff @(posedge clk) begin
        if (buf_we && !busy) frame_mem[buf_addr] <= buf_wdata;
    end
    assign rd_data = frame_mem[rd_addr];

    tx_host_regs u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .done(done), .result(result),
        .start(start), .start_cfg(start_cfg)
    );

    tx_attempt_ctrl #(.ACK_WAIT(ACK_WAIT)) u_ctrl (
        .clk(clk), .rst(rst),
        .start(start), .cfg(start_cfg),
        .frame_done(frame_done), .ack_in(ack_in),
        .frame_go(frame_go), .busy(busy), .done(done), .result(result)
    );

    tx_byte_serializer #(.BUF_AW(BUF_AW), .PRE_LEN(PRE_LEN)) u_ser (
        .clk(clk), .rst(rst), .go(frame_go),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .frame_done(frame_done)
    );

endmodule

// File: tb/frame_tx_retry_bench.sv
module frame_tx_retry_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_LEN    = 4;
    localparam int ACK_WAIT   = 48;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       buf_we = 1'b0;
    logic [5:0] buf_addr = 6'd0;
    logic [7:0] buf_wdata = 8'd0;
    logic       tx_valid;
    logic       tx_ready = 1'b1;
    logic [7:0] tx_data;
    logic       ack_in = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit rdy_rand = 1'b0;
    logic [7:0] bufm [64];
    logic [7:0] cap [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_tx_retry #(.BUF_DEPTH(64), .PRE_LEN(PRE_LEN), .ACK_WAIT(ACK_WAIT)) u_frame_tx_retry (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .ack_in(ack_in)
    );

    // Choose ready for the coming edge, then record the handshake it will make.
    always @(negedge clk) begin
        tx_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
        if (!rst && tx_valid && tx_ready) cap.push_back(tx_data);
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wbuf(input int a, input logic [7:0] d);
        @(negedge clk); buf_we = 1'b1; buf_addr = 6'(a); buf_wdata = d;
        @(negedge clk); buf_we = 1'b0;
    endtask

    task automatic load_frame(input int len);
        bufm[0] = 8'(len);
        for (int i = 1; i <= len; i++) bufm[i] = 8'($urandom);
        for (int i = 0; i <= len; i++) wbuf(i, bufm[i]);
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack_in = 1'b1;
        @(negedge clk); ack_in = 1'b0;
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i <= n; i++) begin
            c = c ^ {bufm[i], 8'h00};
            for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic wait_idle();
        logic [7:0] d;
        do rreg(2'd0, d); while (d[0]);
    endtask

    // Runs one operation and checks stream, status and interrupt.
    task automatic run_op(input logic [7:0] ctrl, input int ack_at, input bit early_ack, input string tag);
        int L = int'(bufm[0]);
        bit ackreq = ctrl[2];
        int lim = int'(ctrl[7:4]);
        bit acked = ackreq && (ack_at >= 0) && (ack_at <= lim);
        int att = !ackreq ? 1 : (acked ? ack_at + 1 : lim + 1);
        bit failx = ackreq && !acked;
        logic [7:0] exp_stat = {4'(att - 1), 3'b000, failx};
        logic [15:0] crc = ref_crc(L);
        logic [7:0] fr [$];
        logic [7:0] d;
        int bad = -1;
        for (int i = 0; i < PRE_LEN; i++) fr.push_back(8'h55);
        fr.push_back(8'hA7);
        for (int i = 0; i <= L; i++) fr.push_back(bufm[i]);
        fr.push_back(crc[7:0]);
        fr.push_back(crc[15:8]);
        cap.delete();
        wreg(2'd0, ctrl);
        rreg(2'd0, d);
        check(d[0] == 1'b1, {"R4 send bit busy ", tag}, d[0], 1);
        for (int a = 0; a < att; a++) begin
            if (early_ack && a == 0) begin
                while (cap.size() < 3) @(negedge clk);
                pulse_ack();
            end
            while (cap.size() < (a + 1) * fr.size()) @(negedge clk);
            if (acked && a == ack_at) begin
                repeat (3) @(negedge clk);
                pulse_ack();
            end
        end
        wait_idle();
        check(cap.size() == att * fr.size(), {"R2 stream length ", tag}, cap.size(), att * fr.size());
        for (int i = 0; i < cap.size() && i < att * fr.size(); i++)
            if (bad < 0 && cap[i] !== fr[i % fr.size()]) bad = i;
        if (bad >= 0) check(1'b0, {"R3 stream byte ", tag}, cap[bad], fr[bad % fr.size()]);
        else check(1'b1, {"R3 stream bytes ", tag}, 0, 0);
        rreg(2'd1, d);
        check(d == exp_stat, {"R6 status ", tag}, d, exp_stat);
        rreg(2'd2, d);
        check(d == 8'h01, {"R5 irq set ", tag}, d, 1);
        rreg(2'd2, d);
        check(d == 8'h00, {"R9 irq cleared ", tag}, d, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
        rreg(2'd0, d); check(d == 8'h30, "R1 ctrl reset", d, 8'h30);
        rreg(2'd1, d); check(d == 8'h00, "R1 status reset", d, 0);
        rreg(2'd2, d); check(d == 8'h00, "R1 irq reset", d, 0);

        // Shortest frame: no payload, no ack request (R5).
        load_frame(5);
        run_op(8'h01, -1, 1'b0, "R5 noack");
        // Ack on first attempt (R6).
        load_frame(9);
        run_op(8'h35, 0, 1'b0, "R6 ack0");
        // Ack on third attempt under backpressure (R6).
        rdy_rand = 1'b1;
        run_op(8'h35, 2, 1'b0, "R6 ack2");
        // No ack, limit 2 (R7).
        run_op(8'h25, -1, 1'b0, "R7 exhaust");
        // Limit 0 (R11).
        load_frame(7);
        run_op(8'h05, -1, 1'b0, "R11 lim0");
        // Ack during transmission is ignored (R8): expect two attempts, status 0x11.
        run_op(8'h15, -1, 1'b1, "R8 early ack");

        // Writes while busy have no effect (R10).
        load_frame(8);
        cap.delete();
        wreg(2'd0, 8'h01);
        while (cap.size() < 4) @(negedge clk);
        wreg(2'd0, 8'hF5);
        wbuf(1, ~bufm[1]);
        wait_idle();
        rreg(2'd0, d);
        check(d == 8'h00, "R10 ctrl unchanged", d, 0);
        rreg(2'd2, d);
        run_op(8'h01, -1, 1'b0, "R10 buffer unchanged");

        // Random mix.
        for (int n = 0; n < 30; n++) begin
            int len = 5 + int'($urandom % 14);
            int lim = int'($urandom % 3);
            bit ar = 1'(($urandom % 3) != 0);
            int ak = int'($urandom % (lim + 2));
            if (ak > lim) ak = -1;
            rdy_rand = 1'($urandom % 2);
            load_frame(len);
            run_op({4'(lim), 1'b0, ar, 1'b0, 1'b1}, ak, 1'b0, "R7 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule